// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable memory with a synchronous burst front end. The address, write data, byte-write controls, chip enables and both address strobes are captured on the rising clock edge. Read data is not held in an output register. It comes straight from the array at the captured address, so a read started at an edge shows its word later in that same clock period. The design has no read pipeline stage.

A burst can start from either of two strobes, and the two follow different enable rules. The processor-side strobe always begins a read. It is ignored when the primary enable is inactive. The controller-side strobe can begin a read or a write, and it deselects the block when the enables are inactive. Once a burst is running, a 2-bit counter steps the low address bits when the advance input is low and holds them when it is high. The counter follows either a linear wrap or an XOR interleave, chosen by an unregistered pin.

The output drivers are modelled as a data bus plus a drive flag. The flag follows an asynchronous active-low output enable. Writes are gated per 9-bit lane. The default depth is 512 words so that elaboration stays small. The full 32K-word arrangement uses `ADDR_W = 15`.

Top module: `fts_burst_sram`

## Requirements
- R1: While reset is held, and after its release until a read is begun, `rvalid` is 0 and the block is deselected.
- R2: A burst start needs `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A controller strobe (`strobe_c_n`=0) with any enable inactive deselects the block. So does a processor strobe with `ce1_n`=0 but `ce2` or `ce3_n` inactive. A deselected block keeps `rvalid` at 0 until a new start.
- R3: A processor strobe while `ce1_n`=1 is ignored. If the controller strobe is high, the cycle is treated as a continuation, and the current address and state are kept.
- R4: A processor strobe with all enables active loads the external address and begins a read. The write controls in that cycle are ignored and the array is not changed.
- R5: Lane i is `wdata[9i+8:9i]`, and `bsel_n[i]` selects it (bit 0 is the lowest lane). With `gw_n`=0 all lanes are written. Otherwise, with `bwe_n`=0, exactly the lanes whose `bsel_n` bit is 0 are written. With `gw_n`=1 and `bwe_n`=1 the cycle is a read, whatever `bsel_n` holds.
- R6: A controller strobe with the processor strobe high and all enables active loads the external address. It begins a write if R5 calls for one, and a read otherwise.
- R7: With both strobes high and `adv_n`=0, in linear order (`order_il`=0), the two low address bits step by +1 modulo 4. The upper bits do not change, so a burst wraps within its aligned group of four.
- R8: In interleaved order (`order_il`=1), the k-th advance uses low bits equal to (start low bits) XOR k.
- R9: With both strobes high and `adv_n`=1, the address is held. The cycle reads or writes that address according to R5.
- R10: After the edge that registers a read, `rdata` equals the array word at that address within the same period. A write to an address is returned by a read of it at the next edge.
- R11: `rvalid` is 0 immediately whenever `oe_n`=1, and also in the period after a write edge.
- R12: During continuation cycles the chip enables are ignored. Bursts keep reading or advancing while they change.
- R13: Holding `strobe_p_n`=1, `strobe_c_n`=0 and `adv_n`=1 with the enables active makes every cycle a single access at a fresh external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data, lane i at bits 9i+8:9i |
| strobe_p_n | input | 1 | Processor-side burst start, active low |
| strobe_c_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte select, active low |
| ce1_n | input | 1 | Primary enable, active low |
| ce2 | input | 1 | Expansion enable, active high |
| ce3_n | input | 1 | Expansion enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rvalid | output | 1 | Bus drive flag (0 = high impedance) |

## Verification
The burst-step properties assume that `order_il` stays fixed for the length of a burst. The bench changes it only just before a controller-strobe start. The read-start properties accept a later change of `oe_n` rather than assume it is stable, because the bench toggles output enable between edges. All inputs are driven to known levels from reset onward, and every read targets an address that was written earlier, since the array is never initialised.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    SB_IDLE  = 2'd0,
    SB_READ  = 2'd1,
    SB_WRITE = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             oe_n,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] wmask,
  output logic             drive
);
  sb_state_e state_q, state_d;
  logic en_all, p_go, c_go;
  logic [LANES-1:0] req_mask;

  assign en_all = !ce1_n && ce2 && !ce3_n;
  assign p_go   = !strobe_p_n && !ce1_n;
  assign c_go   = !strobe_c_n && !p_go;

  always_comb begin
    if (!gw_n)       req_mask = '1;
    else if (!bwe_n) req_mask = ~bsel_n;
    else             req_mask = '0;
  end

  always_comb begin
    load    = 1'b0;
    step    = 1'b0;
    wmask   = '0;
    state_d = state_q;
    if (p_go) begin
      if (en_all) begin
        load    = 1'b1;
        state_d = SB_READ;
      end else begin
        state_d = SB_IDLE;
      end
    end else if (c_go) begin
      if (en_all) begin
        load    = 1'b1;
        wmask   = req_mask;
        state_d = (|req_mask) ? SB_WRITE : SB_READ;
      end else begin
        state_d = SB_IDLE;
      end
    end else if (state_q != SB_IDLE) begin
      step    = !adv_n;
      wmask   = req_mask;
      state_d = (|req_mask) ? SB_WRITE : SB_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SB_IDLE;
    else        state_q <= state_d;
  end

  assign drive = (state_q == SB_READ) && !oe_n;

  AST_WRITE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (|wmask) |=> !drive); // R11
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_c_n && strobe_p_n && ce1_n) |=> !drive); // R2
  AST_PSTART_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p_n && !ce1_n && ce2 && !ce3_n) |=> (drive || oe_n)); // R4
  AST_CONT_IGNORES_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SB_READ && strobe_p_n && strobe_c_n && gw_n && bwe_n)
      |=> (drive || oe_n)); // R12
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int ADDR_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] use_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  addr_q;
  logic [BURST_W-1:0] start_q, cnt_q, cnt_inc, nxt_lsb;

  assign cnt_inc = cnt_q + 1'b1;
  assign nxt_lsb = order_il ? (start_q ^ cnt_inc)
                            : (addr_q[BURST_W-1:0] + 1'b1);

  always_comb begin
    if (load)      use_addr = ext_addr;
    else if (step) use_addr = {addr_q[ADDR_W-1:BURST_W], nxt_lsb};
    else           use_addr = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      addr_q <= use_addr;
      if (load) begin
        start_q <= ext_addr[BURST_W-1:0];
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign cur_addr = addr_q;

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])); // R7
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !order_il) |=>
      addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1'b1)); // R7
  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && order_il) |=>
      (addr_q[BURST_W-1:0] ^ start_q) == BURST_W'($past(cnt_q) + 1'b1)); // R8
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q)); // R9
  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == '1) |=> addr_q[BURST_W-1:0] == start_q); // R7

  logic unused_hi;
  assign unused_hi = (HI_W > 0);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wmask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
  parameter int ADDR_W  = 9,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    oe_n,
  input  logic                    order_il,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, step, drive;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] use_addr, cur_addr;
  logic [DATA_W-1:0] arr_data;

  sbsram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
    .load(load), .step(step), .wmask(wmask), .drive(drive)
  );

  sbsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .order_il(order_il), .ext_addr(addr_in),
    .use_addr(use_addr), .cur_addr(cur_addr)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wmask(wmask), .waddr(use_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(arr_data)
  );

  assign rvalid = drive;
  assign rdata  = drive ? arr_data : '0;

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_p_n && !strobe_c_n && !ce1_n && ce2 && !ce3_n && gw_n && bwe_n)
      |=> (rvalid || oe_n)); // R13
  AST_OE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !rvalid) |-> (rdata == '0)); // R11
endmodule

// File: tb/fts_burst_sram_bench.sv
`timescale 1ns/1ps
module fts_burst_sram_bench;
  localparam logic H = 1'b1;
  localparam logic L = 1'b0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  addr_in;
  logic [35:0] wdata;
  logic        strobe_p_n, strobe_c_n, adv_n, gw_n, bwe_n;
  logic [3:0]  bsel_n;
  logic        ce1_n, ce2, ce3_n, oe_n, order_il;
  logic [35:0] rdata;
  logic        rvalid;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fts_burst_sram u_fts_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
    .order_il(order_il), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic p_n, c_n, adv, gw, bwe;
    logic [3:0] bsel;
    logic [8:0] addr, pat;
    logic ev;
    logic [35:0] ed;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{"R6 ", H, L, H, L, H, 4'hF, 9'h010, 9'h0A1, L, 36'h0},
    '{"R7 ", H, H, L, L, H, 4'hF, 9'h000, 9'h0B2, L, 36'h0},
    '{"R7 ", H, H, L, L, H, 4'hF, 9'h000, 9'h0C3, L, 36'h0},
    '{"R7 ", H, H, L, L, H, 4'hF, 9'h000, 9'h0D4, L, 36'h0},
    '{"R4 ", L, H, H, L, H, 4'hF, 9'h010, 9'h1FF, H, {4{9'h0A1}}},
    '{"R7 ", H, H, L, H, H, 4'hF, 9'h000, 9'h000, H, {4{9'h0B2}}},
    '{"R9 ", H, H, H, H, H, 4'hF, 9'h000, 9'h000, H, {4{9'h0B2}}},
    '{"R7 ", H, H, L, H, H, 4'hF, 9'h000, 9'h000, H, {4{9'h0C3}}},
    '{"R7 ", H, H, L, H, H, 4'hF, 9'h000, 9'h000, H, {4{9'h0D4}}},
    '{"R7 ", H, H, L, H, H, 4'hF, 9'h000, 9'h000, H, {4{9'h0A1}}},
    '{"R5 ", H, L, H, H, L, 4'hA, 9'h011, 9'h155, L, 36'h0},
    '{"R5 ", H, L, H, H, H, 4'hF, 9'h011, 9'h000, H, {9'h0B2, 9'h155, 9'h0B2, 9'h155}},
    '{"R5 ", H, L, H, H, H, 4'h0, 9'h012, 9'h000, H, {4{9'h0C3}}}
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check(input string req, input logic ev, input logic [35:0] ed);
    total++;
    if (rvalid !== ev || (ev && rdata !== ed)) begin
      bad++;
      $display("FAIL %s: got rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
  endtask

  task automatic enables_on();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic c_read(input logic [8:0] a);
    quiet(); strobe_c_n = 1'b0; addr_in = a;
    tick();
  endtask

  task automatic c_write(input logic [8:0] a, input logic [8:0] p);
    quiet(); strobe_c_n = 1'b0; gw_n = 1'b0; addr_in = a; wdata = {4{p}};
    tick();
  endtask

  task automatic advance();
    quiet(); adv_n = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); enables_on();
    oe_n = 1'b0; order_il = 1'b0; addr_in = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, 36'h0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", 1'b0, 36'h0);

    foreach (TBL[i]) begin
      strobe_p_n = TBL[i].p_n; strobe_c_n = TBL[i].c_n; adv_n = TBL[i].adv;
      gw_n = TBL[i].gw; bwe_n = TBL[i].bwe; bsel_n = TBL[i].bsel;
      addr_in = TBL[i].addr; wdata = {4{TBL[i].pat}};
      tick();
      check($sformatf("%s row %0d", TBL[i].tag, i), TBL[i].ev, TBL[i].ed);
    end

    // R11: output enable acts without a clock edge
    quiet();
    oe_n = 1'b1; #1;
    check("R11 oe high", 1'b0, 36'h0);
    oe_n = 1'b0; #1;
    check("R11 oe low", 1'b1, {4{9'h0C3}});

    // R3: processor strobe with ce1_n high is a hold
    c_read(9'h013);
    check("R3 setup", 1'b1, {4{9'h0D4}});
    quiet(); strobe_p_n = 1'b0; ce1_n = 1'b1; addr_in = 9'h010;
    tick();
    check("R3 ignored strobe", 1'b1, {4{9'h0D4}});

    // R12: enables changing mid-burst are ignored
    quiet(); adv_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    tick();
    check("R12 advance while disabled", 1'b1, {4{9'h0A1}});
    enables_on();

    // R8: interleaved order from start 2 -> 3, 0, 1
    order_il = 1'b1;
    c_read(9'h012);
    check("R8 start", 1'b1, {4{9'h0C3}});
    advance();
    check("R8 step1", 1'b1, {4{9'h0D4}});
    advance();
    check("R8 step2", 1'b1, {4{9'h0A1}});
    advance();
    check("R8 step3", 1'b1, {9'h0B2, 9'h155, 9'h0B2, 9'h155});
    order_il = 1'b0;

    // R2: deselect paths
    c_read(9'h010);
    quiet(); strobe_p_n = 1'b0; ce3_n = 1'b1; addr_in = 9'h010;
    tick();
    check("R2 processor strobe ce3 off", 1'b0, 36'h0);
    enables_on();
    c_read(9'h010);
    check("R2 re-read", 1'b1, {4{9'h0A1}});
    ce1_n = 1'b1;
    c_read(9'h010);
    check("R2 controller strobe ce1 off", 1'b0, 36'h0);
    enables_on(); ce2 = 1'b0;
    c_read(9'h010);
    check("R2 controller strobe ce2 off", 1'b0, 36'h0);
    enables_on();
    advance();
    check("R2 stays deselected", 1'b0, 36'h0);

    // R13 and R10: single accesses at fresh addresses
    c_write(9'h020, 9'h011);
    check("R11 write hides bus", 1'b0, 36'h0);
    c_write(9'h021, 9'h022);
    check("R13 write second", 1'b0, 36'h0);
    c_read(9'h020);
    check("R13 read first", 1'b1, {4{9'h011}});
    c_read(9'h021);
    check("R13 read second", 1'b1, {4{9'h022}});
    c_write(9'h020, 9'h033);
    c_read(9'h020);
    check("R10 write then read", 1'b1, {4{9'h033}});

    summary();
    $finish;
  end
endmodule